// File: doc/BRIEF.md
# Configurable Register/Latch Output Cell

This block is a bank of output cells. Each cell takes one sum-of-products term from the logic array and drives two copies of the result: one to the pin and one back into the logic array as feedback. Configuration inputs per cell choose among four run-time modes: a combinational pass-through, an edge-triggered D flip-flop, an edge-triggered T flip-flop, or a level-sensitive latch. Two more bits per cell choose which edge or level of the shared clock/latch-enable is active, and whether the result is complemented before it leaves the cell.

Each cell holds two small state machines, one for the edge-triggered element and one for the latch. Each machine has two states, HOLD_LO and HOLD_HI. The edge machine moves on the active edge. In D mode it goes to HOLD_HI when the input is 1 and to HOLD_LO when the input is 0. In T mode it goes HOLD_LO to HOLD_HI or HOLD_HI to HOLD_LO when the input is 1, and stays put when the input is 0. In the other modes it stays put. The latch machine takes HOLD_HI or HOLD_LO from the input whenever its enable is at the transparent level, and stays put otherwise. An asynchronous reset forces both machines to HOLD_LO. A mode selector picks which machine, or the raw input, reaches the output. The polarity stage follows the selector.

Top module: `sop_out_cell`

## Requirements
- R1: While `rst_i` is high, both storage elements of every cell are held at 0. A cell in D, T or latch mode then drives `pin_o` equal to its `data_inv_i` bit.
- R2: Mode code 2'b00 (combinational) drives `pin_o` from `sop_i ^ data_inv_i` at once, whatever the clock does.
- R3: Mode code 2'b01 (D register) loads `sop_i` on each active edge and keeps its value at every other time.
- R4: Mode code 2'b10 (T register) inverts its stored value on an active edge when `sop_i` is 1, and keeps it when `sop_i` is 0.
- R5: When the cell's `clk_inv_i` bit is 0, the active edge is the rising edge of `clk_le_i` and the latch is transparent while `clk_le_i` is 0. When the bit is 1, the active edge is the falling edge and the latch is transparent while `clk_le_i` is 1.
- R6: Mode code 2'b11 (latch) makes the output follow `sop_i` while the enable is at its transparent level, and hold the last value when the enable leaves that level.
- R7: A `data_inv_i` bit of 1 complements the cell's output. The inversion sits after the storage elements, so the stored value is unaffected.
- R8: `fb_o` always carries the same value as `pin_o`, polarity included.
- R9: The edge element updates only in modes 2'b01 and 2'b10 and holds in the others. The latch element tracks its input at the transparent level in every mode. A change of mode therefore exposes the value that element already holds.
- R10: Each cell's configuration and data affect that cell only. The mode of cell g is `mode_i[2g+1:2g]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_i | input | 1 | Asynchronous reset, active high, clears all storage |
| clk_le_i | input | 1 | Shared clock for the registers and enable for the latches |
| sop_i | input | LANES | Sum-of-products input, one bit per cell |
| mode_i | input | 2*LANES | Mode code per cell: 00 comb, 01 D, 10 T, 11 latch |
| clk_inv_i | input | LANES | Per-cell clock/enable polarity select |
| data_inv_i | input | LANES | Per-cell output complement select |
| pin_o | output | LANES | Value toward the pin |
| fb_o | output | LANES | Feedback copy of the pin value |

## Verification
The properties are sampled on the rising edge of `clk_le_i`, so they check only cells whose `clk_inv_i` is 0. They assume three things. `clk_inv_i` changes only while reset is held. `sop_i`, `mode_i` and `data_inv_i` are steady around each clock edge. Every reset pulse spans at least one rising edge. The stimulus respects all three. It picks a new polarity vector only inside a reset pulse, and it clocks once while reset is held. It changes data and configuration only a quarter period away from any clock transition. Between the two clock edges it also changes `sop_i` alone, so the latch is exercised in both its transparent and its opaque phase.

// File: rtl/outcell_pkg.sv
package outcell_pkg;

    typedef enum logic [1:0] {
        MODE_COMB  = 2'b00,
        MODE_DREG  = 2'b01,
        MODE_TREG  = 2'b10,
        MODE_LATCH = 2'b11
    } cell_mode_e;

    typedef enum logic {
        HOLD_LO = 1'b0,
        HOLD_HI = 1'b1
    } store_e;

    localparam int MODE_BITS = 2;

endpackage

// File: rtl/outcell_edge_store.sv
module outcell_edge_store
    import outcell_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_i,
    input  cell_mode_e mode_i,
    input  logic       sop_i,
    output logic       q_o
);

    store_e cur_q;
    store_e nxt_d;

    // next-state selection: D loads, T flips on 1, other modes hold
    always_comb begin
        nxt_d = cur_q;
        unique case (mode_i)
            MODE_DREG: nxt_d = sop_i ? HOLD_HI : HOLD_LO;
            MODE_TREG: begin
                if (sop_i) begin
                    nxt_d = (cur_q == HOLD_HI) ? HOLD_LO : HOLD_HI;
                end
            end
            MODE_COMB,
            MODE_LATCH: nxt_d = cur_q;
            default:    nxt_d = cur_q;
        endcase
    end

    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) begin
            cur_q <= HOLD_LO;
        end else begin
            cur_q <= nxt_d;
        end
    end

    always_comb begin
        q_o = (cur_q == HOLD_HI);
    end

endmodule

// File: rtl/outcell_level_store.sv
module outcell_level_store
    import outcell_pkg::*;
(
    input  logic rst_i,
    input  logic open_i,
    input  logic sop_i,
    output logic q_o
);

    store_e lat_q;

    always_latch begin
        if (rst_i) begin
            lat_q <= HOLD_LO;
        end else if (open_i) begin
            lat_q <= sop_i ? HOLD_HI : HOLD_LO;
        end
    end

    always_comb begin
        q_o = (lat_q == HOLD_HI);
    end

endmodule

// File: rtl/outcell_lane.sv
module outcell_lane
    import outcell_pkg::*;
(
    input  logic       rst_i,
    input  logic       clk_le_i,
    input  logic       sop_i,
    input  cell_mode_e mode_i,
    input  logic       clk_inv_i,
    input  logic       data_inv_i,
    output logic       pin_o,
    output logic       fb_o
);

    logic eff_clk;
    logic le_open;
    logic edge_q;
    logic level_q;
    logic sel_val;

    // polarity applied to the shared clock/enable
    assign eff_clk = clk_le_i ^ clk_inv_i;
    assign le_open = ~eff_clk;

    outcell_edge_store u_edge (
        .clk_i  (eff_clk),
        .rst_i  (rst_i),
        .mode_i (mode_i),
        .sop_i  (sop_i),
        .q_o    (edge_q)
    );

    outcell_level_store u_level (
        .rst_i  (rst_i),
        .open_i (le_open),
        .sop_i  (sop_i),
        .q_o    (level_q)
    );

    always_comb begin
        sel_val = sop_i;
        unique case (mode_i)
            MODE_COMB:  sel_val = sop_i;
            MODE_DREG,
            MODE_TREG:  sel_val = edge_q;
            MODE_LATCH: sel_val = level_q;
            default:    sel_val = sop_i;
        endcase
    end

    always_comb begin
        pin_o = sel_val ^ data_inv_i;
        fb_o  = sel_val ^ data_inv_i;
    end

endmodule

// File: rtl/sop_out_cell.sv
module sop_out_cell
    import outcell_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic                           rst_i,
    input  logic                           clk_le_i,
    input  logic [LANES-1:0]               sop_i,
    input  logic [LANES-1:0][MODE_BITS-1:0] mode_i,
    input  logic [LANES-1:0]               clk_inv_i,
    input  logic [LANES-1:0]               data_inv_i,
    output logic [LANES-1:0]               pin_o,
    output logic [LANES-1:0]               fb_o
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        outcell_lane u_lane (
            .rst_i      (rst_i),
            .clk_le_i   (clk_le_i),
            .sop_i      (sop_i[g]),
            .mode_i     (cell_mode_e'(mode_i[g])),
            .clk_inv_i  (clk_inv_i[g]),
            .data_inv_i (data_inv_i[g]),
            .pin_o      (pin_o[g]),
            .fb_o       (fb_o[g])
        );
    end

endmodule

// File: rtl/outcell_checker.sv
module outcell_checker
    import outcell_pkg::*;
#(
    parameter int LANES = 4
) (
    input logic                            rst_i,
    input logic                            clk_le_i,
    input logic [LANES-1:0]                sop_i,
    input logic [LANES-1:0][MODE_BITS-1:0] mode_i,
    input logic [LANES-1:0]                clk_inv_i,
    input logic [LANES-1:0]                data_inv_i,
    input logic [LANES-1:0]                pin_o,
    input logic [LANES-1:0]                fb_o
);

    for (genvar g = 0; g < LANES; g++) begin : g_chk

        p_comb_follow_r2: assert property (@(posedge clk_le_i) disable iff (rst_i)
            (mode_i[g] == MODE_COMB) |-> (pin_o[g] == (sop_i[g] ^ data_inv_i[g])));

        p_dreg_load_r3: assert property (@(posedge clk_le_i) disable iff (rst_i)
            (mode_i[g] == MODE_DREG && !clk_inv_i[g]) |=>
            (mode_i[g] != MODE_DREG || clk_inv_i[g] ||
             pin_o[g] == ($past(sop_i[g]) ^ data_inv_i[g])));

        p_treg_flip_r4: assert property (@(posedge clk_le_i) disable iff (rst_i)
            (mode_i[g] == MODE_TREG && !clk_inv_i[g] && sop_i[g]) |=>
            (mode_i[g] != MODE_TREG || clk_inv_i[g] || !$stable(data_inv_i[g]) ||
             pin_o[g] != $past(pin_o[g])));

        p_latch_open_r6: assert property (@(posedge clk_le_i) disable iff (rst_i)
            (mode_i[g] == MODE_LATCH && !clk_inv_i[g]) |->
            (pin_o[g] == (sop_i[g] ^ data_inv_i[g])));

        p_fb_copy_r8: assert property (@(posedge clk_le_i) disable iff (rst_i)
            $stable(mode_i[g]) |-> (fb_o[g] == pin_o[g]));
    end

endmodule

bind sop_out_cell outcell_checker #(.LANES(LANES)) u_outcell_checker (.*);

// File: tb/test_sop_out_cell.sv
module test_sop_out_cell;
    import outcell_pkg::*;

    localparam int LANES      = 4;
    localparam int CLK_PERIOD = 8;
    localparam int QTR        = CLK_PERIOD / 4;

    logic                   rst;
    logic                   clk_le;
    logic [LANES-1:0]       sop;
    logic [LANES-1:0][1:0]  mode;
    logic [LANES-1:0]       cinv;
    logic [LANES-1:0]       dinv;
    logic [LANES-1:0]       pin;
    logic [LANES-1:0]       fb;

    logic [LANES-1:0]       ff_m;
    logic [LANES-1:0]       lat_m;
    int total;
    int bad;

    sop_out_cell #(.LANES(LANES)) i_sop_out_cell (
        .rst_i      (rst),
        .clk_le_i   (clk_le),
        .sop_i      (sop),
        .mode_i     (mode),
        .clk_inv_i  (cinv),
        .data_inv_i (dinv),
        .pin_o      (pin),
        .fb_o       (fb)
    );

    function automatic logic exp_pin(int g);
        logic v;
        case (mode[g])
            2'b00:   v = sop[g];
            2'b01,
            2'b10:   v = ff_m[g];
            default: v = lat_m[g];
        endcase
        return v ^ dinv[g];
    endfunction

    function automatic string req_of(int g);
        string r;
        if (rst) return "R1";
        case (mode[g])
            2'b00:   r = "R2";
            2'b01:   r = "R3";
            2'b10:   r = "R4";
            default: r = "R6";
        endcase
        if (cinv[g]) r = {r, "/R5"};
        if (dinv[g]) r = {r, "/R7"};
        return {r, "/R9/R10"};
    endfunction

    // reference model update after any input change
    task automatic model_step(input logic prev_clk);
        for (int g = 0; g < LANES; g++) begin
            if (rst) begin
                ff_m[g]  = 1'b0;
                lat_m[g] = 1'b0;
            end else begin
                if (!(prev_clk ^ cinv[g]) && (clk_le ^ cinv[g])) begin
                    if (mode[g] == 2'b01) ff_m[g] = sop[g];
                    else if (mode[g] == 2'b10 && sop[g]) ff_m[g] = ~ff_m[g];
                end
                if (!(clk_le ^ cinv[g])) lat_m[g] = sop[g];
            end
        end
    endtask

    task automatic check_all();
        #(QTR);
        for (int g = 0; g < LANES; g++) begin
            logic e;
            e = exp_pin(g);
            total++;
            if (pin[g] !== e) begin
                bad++;
                $display("FAIL %s lane %0d pin act=%b exp=%b t=%0t", req_of(g), g, pin[g], e, $time);
            end
            total++;
            if (fb[g] !== e) begin
                bad++;
                $display("FAIL R8 lane %0d fb act=%b exp=%b t=%0t", g, fb[g], e, $time);
            end
        end
    endtask

    task automatic set_clk(input logic v);
        logic prev;
        prev   = clk_le;
        clk_le = v;
        model_step(prev);
        check_all();
    endtask

    task automatic set_data(input logic [LANES-1:0] s, input logic [2*LANES-1:0] m,
                            input logic [LANES-1:0] d);
        sop  = s;
        mode = m;
        dinv = d;
        model_step(clk_le);
        check_all();
    endtask

    task automatic set_sop(input logic [LANES-1:0] s);
        sop = s;
        model_step(clk_le);
        check_all();
    endtask

    // reset pulse with a new polarity vector, spanning one rising edge (R1)
    task automatic do_reset(input logic [LANES-1:0] ci);
        rst  = 1'b1;
        cinv = ci;
        model_step(clk_le);
        check_all();
        set_clk(1'b1);
        set_clk(1'b0);
        rst = 1'b0;
        model_step(clk_le);
        check_all();
    endtask

    task automatic cycle(input logic [LANES-1:0] s0, input logic [LANES-1:0] s1,
                         input logic [2*LANES-1:0] m, input logic [LANES-1:0] d);
        set_data(s0, m, d);
        set_clk(1'b1);
        set_sop(s1);
        set_clk(1'b0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        total++;
        bad++;
        $display("FAIL watchdog expired act=running exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int unsigned seed;
        total  = 0;
        bad    = 0;
        rst    = 1'b1;
        clk_le = 1'b0;
        sop    = '0;
        mode   = {LANES{2'b01}};
        cinv   = '0;
        dinv   = 4'b0101;
        ff_m   = '0;
        lat_m  = '0;
        seed   = $urandom(32'h5eed);
        #(QTR);

        // R1: reset state in stored modes, with and without complement
        do_reset(4'b0000);

        // R3: D mode loads on rising edge, holds otherwise
        cycle(4'b1010, 4'b0101, {LANES{2'b01}}, 4'b0000);
        cycle(4'b0110, 4'b1111, {LANES{2'b01}}, 4'b0000);

        // R4: T mode toggles with 1, holds with 0
        cycle(4'b1111, 4'b0000, {LANES{2'b10}}, 4'b0000);
        cycle(4'b1111, 4'b1111, {LANES{2'b10}}, 4'b0000);
        cycle(4'b0011, 4'b0000, {LANES{2'b10}}, 4'b0000);

        // R2/R7: combinational with complement
        cycle(4'b1100, 4'b0011, {LANES{2'b00}}, 4'b1010);

        // R5/R6: latch with mixed enable polarity, both phases
        do_reset(4'b0101);
        cycle(4'b1001, 4'b0110, {LANES{2'b11}}, 4'b0000);
        cycle(4'b1111, 4'b0000, {LANES{2'b11}}, 4'b0011);

        // R5: falling-edge registers, R9: switch from latch into D and back
        cycle(4'b1010, 4'b0101, {LANES{2'b01}}, 4'b0000);
        cycle(4'b0101, 4'b1111, {LANES{2'b11}}, 4'b0000);

        // random episodes, R10 through per-lane mixes
        for (int ep = 0; ep < 12; ep++) begin
            do_reset(LANES'($urandom));
            for (int c = 0; c < 60; c++) begin
                cycle(LANES'($urandom), LANES'($urandom),
                      (2*LANES)'($urandom), LANES'($urandom));
            end
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule